// File: doc/BRIEF.md
# Packet Replay Stream Buffer

This block sits between a byte-wide packet source and a half-duplex transmitter that has to resend a frame from its start when a collision is detected early in the frame. Bytes accepted on the input stream are written into a circular store, and every output beat is read back from that store. No path lets input bytes reach the output directly.

The consumer tracks the frame on the wire. While fewer than `REPLAY_BYTES` beats of the current packet have been handed over, it may pulse `replay`. The output then drops, and the packet streams again from its first byte. The first bytes of a packet stay protected until one of two things happens: the consumer pulses `done`, or the replay window has been passed. Reading the final byte does not release them, so a short frame can still be replayed after its last byte went out. After the last beat the output stays idle until `done` arrives, and only then does the next packet start.

Top module: `replay_buffer`

## Requirements
- R1: Output beats carry the accepted bytes and their last flags in the order they were accepted. Each packet appears complete, ending with its last-flagged byte.
- R2: Right after reset, `m_valid` is 0 and `s_ready` is 1.
- R3: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_last` hold their values into the next cycle. An accepted replay is the only exception.
- R4: A `replay` pulse is accepted if fewer than `REPLAY_BYTES` beats of the current packet have been handshaked since its start or since the last accepted replay. In the next cycle `m_valid` is 0, and the stream then restarts from the packet's first byte.
- R5: A `replay` pulse is ignored once `REPLAY_BYTES` beats of the current packet have been handshaked. A stalled beat stays on the output and the stream continues with the next byte.
- R6: Once the last-flagged beat has been handshaked, `m_valid` stays 0 until `done` or an accepted replay, even if later packets are stored. A replay at this point restarts a short packet from its first byte.
- R7: `done` has an effect only after the last beat of the current packet has been handshaked. Earlier, it leaves the stream and the replay capability unchanged.
- R8: While the replay window of the current packet is open, its storage is not reused. `s_ready` falls once `DEPTH` bytes are held from the packet's first byte onward. After `done`, the finished packet's slots are returned.
- R9: Once `REPLAY_BYTES` beats of a packet have been handshaked, slots free up as bytes are read. A packet longer than `DEPTH` therefore passes completely without `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | DATA_W | Input stream byte |
| s_valid | input | 1 | Input byte present |
| s_last | input | 1 | Input byte ends its packet |
| s_ready | output | 1 | Buffer can take a byte |
| m_data | output | DATA_W | Output stream byte |
| m_valid | output | 1 | Output byte present |
| m_last | output | 1 | Output byte ends its packet |
| m_ready | input | 1 | Consumer takes the output byte |
| replay | input | 1 | Restart the current packet from its first byte |
| done | input | 1 | Consumer has finished the current packet |

## Verification
Three pointers drive the block: the packet head, the read position and the count of sent beats. An error in the head pointer or the sent count shows up on the very next replay, as a wrong first byte or as a replay that is wrongly accepted or ignored, one cycle after the pulse. An error in the release boundary shows as `s_ready` rising too early, which lets protected bytes be overwritten and corrupts a later replay. It can also show as `s_ready` stuck low, which stalls a packet longer than the store before its last byte. Random packet lengths, replay points and early `done` pulses are mixed with a directed fill-to-capacity run, so each of these symptoms is reached within a few dozen cycles.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  typedef enum logic {
    RD_STREAM = 1'b0,
    RD_TAIL   = 1'b1
  } rd_phase_e;
endpackage

// File: rtl/rpb_store.sv
// Circular byte store: one write port, one registered read port.
// The read register doubles as the output data register.
module rpb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  logic [DATA_W:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_last, wr_data};
    if (rd_en) {rd_last, rd_data} <= mem[rd_addr];
  end
endmodule

// File: rtl/rpb_fill.sv
// Write side: the pointer advances on each accepted byte; space is
// measured against the release boundary given by the read side.
module rpb_fill #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [PW-1:0] release_ptr,
  output logic          in_ready,
  output logic          wr_en,
  output logic [PW-1:0] wr_ptr
);
  logic [PW-1:0] held;

  // held ranges 0..DEPTH; its top bit is set only when the store is full
  assign held     = wr_ptr - release_ptr;
  assign in_ready = ~held[PW-1];
  assign wr_en    = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst)        wr_ptr <= '0;
    else if (wr_en) wr_ptr <= wr_ptr + PW'(1);
  end
endmodule

// File: rtl/rpb_replay_ctrl.sv
// Read side: output valid, read pointer, packet head, sent-beat count
// and the end-of-packet wait for the consumer's done.
module rpb_replay_ctrl
  import rpb_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int REPLAY_BYTES = 56,
  localparam int PW          = $clog2(DEPTH) + 1,
  localparam int CW          = $clog2(REPLAY_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] wr_ptr,
  input  logic          out_ready,
  input  logic          out_last,
  input  logic          replay_req,
  input  logic          done_req,
  output logic          out_valid,
  output logic          fetch,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] release_ptr,
  output logic          win_open
);
  rd_phase_e     phase;
  logic [PW-1:0] head_ptr;
  logic [CW-1:0] sent_cnt;
  logic          beat_done, take_replay, take_done;

  assign win_open    = (sent_cnt != CW'(REPLAY_BYTES));
  assign beat_done   = out_valid & out_ready;
  assign take_replay = replay_req & win_open;
  assign take_done   = done_req & (phase == RD_TAIL) & ~out_valid;
  // While the window is open the packet head is protected; afterwards
  // only bytes not yet copied into the output register are held.
  assign release_ptr = win_open ? head_ptr : rd_ptr;
  assign fetch       = (phase == RD_STREAM) && (rd_ptr != wr_ptr) &&
                       (!out_valid || (out_ready && !out_last)) && !take_replay;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= RD_STREAM;
      head_ptr  <= '0;
      rd_ptr    <= '0;
      sent_cnt  <= '0;
      out_valid <= 1'b0;
    end else if (take_replay) begin
      rd_ptr    <= head_ptr;
      sent_cnt  <= '0;
      out_valid <= 1'b0;
      phase     <= RD_STREAM;
    end else if (take_done) begin
      head_ptr  <= rd_ptr;
      sent_cnt  <= '0;
      phase     <= RD_STREAM;
    end else begin
      if (beat_done && win_open) sent_cnt <= sent_cnt + CW'(1);
      if (fetch) begin
        rd_ptr    <= rd_ptr + PW'(1);
        out_valid <= 1'b1;
      end else if (beat_done) begin
        out_valid <= 1'b0;
      end
      if (beat_done && out_last) phase <= RD_TAIL;
    end
  end
endmodule

// File: rtl/replay_buffer.sv
module replay_buffer #(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 64,
  parameter int REPLAY_BYTES = 56,
  localparam int AW          = $clog2(DEPTH),
  localparam int PW          = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  output logic              m_last,
  input  logic              m_ready,
  input  logic              replay,
  input  logic              done
);
  logic [PW-1:0] wr_ptr, rd_ptr, release_ptr;
  logic          wr_en, fetch, win_open;

  rpb_fill #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst(rst), .in_valid(s_valid), .release_ptr(release_ptr),
    .in_ready(s_ready), .wr_en(wr_en), .wr_ptr(wr_ptr)
  );

  rpb_replay_ctrl #(.DEPTH(DEPTH), .REPLAY_BYTES(REPLAY_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ptr(wr_ptr), .out_ready(m_ready),
    .out_last(m_last), .replay_req(replay), .done_req(done),
    .out_valid(m_valid), .fetch(fetch), .rd_ptr(rd_ptr),
    .release_ptr(release_ptr), .win_open(win_open)
  );

  rpb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_ptr[AW-1:0]), .wr_data(s_data),
    .wr_last(s_last), .rd_en(fetch), .rd_addr(rd_ptr[AW-1:0]),
    .rd_data(m_data), .rd_last(m_last)
  );
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_last,
  input logic [DATA_W-1:0] m_data,
  input logic              replay,
  input logic              done,
  input logic              win_open
);
  // Tracks the wait between the last handshake and done/replay.
  logic in_tail;
  always_ff @(posedge clk) begin
    if (rst)                                in_tail <= 1'b0;
    else if (replay && win_open)            in_tail <= 1'b0;
    else if (done && in_tail && !m_valid)   in_tail <= 1'b0;
    else if (m_valid && m_ready && m_last)  in_tail <= 1'b1;
  end

  p_stall_stable_r3: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready && !(replay && win_open)
    |=> m_valid && $stable(m_data) && $stable(m_last));

  p_replay_gap_r4: assert property (@(posedge clk) disable iff (rst)
    replay && win_open |=> !m_valid);

  p_replay_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    replay && !win_open && m_valid && !m_ready |=> m_valid && $stable(m_data));

  p_tail_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    in_tail |-> !m_valid);
endmodule

bind replay_buffer rpb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .m_valid(m_valid), .m_ready(m_ready),
  .m_last(m_last), .m_data(m_data), .replay(replay), .done(done),
  .win_open(win_open)
);

// File: tb/sim_replay_buffer.sv
module sim_replay_buffer;
  localparam int CLK_NS = 10;
  localparam int DW     = 8;
  localparam int DEPTH  = 8;
  localparam int WIN    = 6;
  localparam int NPKT   = 40;
  localparam int MAXB   = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] s_data = '0, m_data;
  logic s_valid = 0, s_last = 0, s_ready, m_valid, m_last;
  logic m_ready = 0, replay = 0, done = 0;

  always #(CLK_NS/2) clk = ~clk;

  replay_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .REPLAY_BYTES(WIN)) u0 (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .m_data(m_data),
    .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
    .replay(replay), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_data [MAXB];
  bit         exp_last [MAXB];
  int pstart [NPKT];
  int plen   [NPKT];
  int total = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pick(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  // random-phase state
  int  src_i = 0, pk = 0, bi = 0, rp = 0, dpt = 0, waitc = 0;
  bit  replayed = 0, early = 0, expect_gap = 0, prev_stall = 0, r7_pend = 0;
  logic [7:0] prev_data = '0;
  logic       prev_last = 0;

  task automatic new_pkt();
    bi       = 0;
    replayed = 0;
    rp       = pick(0, plen[pk] + plen[pk] / 2 + 1);
    early    = ($urandom % 3) == 0;
    dpt      = pick(0, plen[pk] - 1);
    r7_pend  = 0;
  endtask

  task automatic do_reset();
    rst = 1; s_valid = 0; m_ready = 0; replay = 0; done = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!m_valid, "R2", m_valid, 0);
    check(s_ready, "R2", s_ready, 1);
  endtask

  // directed source: packet A (3 bytes A0..) then packet B (20 bytes B0..)
  int dn = 0;
  task automatic src_dir();
    if (dn < 23) begin
      s_valid = 1;
      s_data  = (dn < 3) ? 8'(160 + dn) : 8'(176 + dn - 3);
      s_last  = (dn == 2) || (dn == 22);
    end else s_valid = 0;
    if (s_valid && s_ready) dn++;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NPKT; p++) begin
      pstart[p] = total;
      plen[p]   = pick(1, 20);
      for (int b = 0; b < plen[p]; b++) begin
        exp_data[total] = 8'($urandom);
        exp_last[total] = (b == plen[p] - 1);
        total++;
      end
    end
    do_reset();
    new_pkt();

    // ---------------- random phase ----------------
    while (pk < NPKT) begin
      int len, base;
      bit taken;
      @(negedge clk);
      // source
      if (src_i < total) begin
        s_valid = ($urandom % 4) != 0;
        s_data  = exp_data[src_i];
        s_last  = exp_last[src_i];
      end else s_valid = 0;
      if (s_valid && s_ready) src_i++;
      // stall stability (R3)
      if (prev_stall)
        check(m_valid && m_data == prev_data && m_last == prev_last, "R3", m_data, prev_data);
      // consumer
      m_ready = 0; replay = 0; done = 0; taken = 0;
      if (expect_gap) begin
        check(!m_valid, "R4", m_valid, 0);
        expect_gap = 0;
      end
      len  = plen[pk];
      base = pstart[pk];
      if (bi == len) begin
        check(!m_valid, "R6", m_valid, 0);
        if (!replayed && rp == len) begin
          replay = 1; replayed = 1;
          if (len < WIN) begin bi = 0; expect_gap = 1; taken = 1; end
        end else if (waitc > 0) waitc--;
        else begin
          done = 1;
          pk++;
          if (pk < NPKT) new_pkt();
        end
      end else if (!replayed && rp == bi) begin
        replay = 1; replayed = 1;
        if (bi < WIN) begin bi = 0; expect_gap = 1; taken = 1; end
      end else if (early && dpt == bi) begin
        done = 1; early = 0; r7_pend = 1;
      end else begin
        m_ready = ($urandom % 3) != 0;
        if (m_valid && m_ready) begin
          string tag;
          tag = r7_pend ? "R7" : ((replayed && rp >= WIN && bi >= rp) ? "R5" : "R1");
          check(m_data == exp_data[base + bi] && m_last == (bi == len - 1), tag,
                m_data, exp_data[base + bi]);
          r7_pend = 0;
          bi++;
          if (bi == len) waitc = pick(0, 3);
        end
      end
      prev_stall = m_valid && !m_ready && !taken;
      prev_data  = m_data;
      prev_last  = m_last;
    end
    @(negedge clk);
    done = 0; replay = 0; m_ready = 0; s_valid = 0;

    // ---------------- directed: capacity and release ----------------
    do_reset();
    dn = 0;
    repeat (30) begin @(negedge clk); m_ready = 0; src_dir(); end
    check(dn == DEPTH, "R8", dn, DEPTH);       // head held from packet start
    begin
      int k = 0;
      for (int c = 0; c < 20 && k < 3; c++) begin
        @(negedge clk); src_dir(); m_ready = 1;
        if (m_valid) begin
          check(m_data == 8'(160 + k) && m_last == (k == 2), "R1", m_data, 160 + k);
          k++;
        end
      end
      repeat (4) begin @(negedge clk); m_ready = 0; src_dir(); end
      check(dn == DEPTH, "R8", dn, DEPTH);     // short packet read, still protected
      check(!m_valid, "R6", m_valid, 0);       // next packet held back
      @(negedge clk); replay = 1; src_dir();
      @(negedge clk); replay = 0; src_dir();
      check(!m_valid, "R4", m_valid, 0);
      k = 0;
      for (int c = 0; c < 20 && k < 3; c++) begin
        @(negedge clk); src_dir(); m_ready = 1;
        if (m_valid) begin
          check(m_data == 8'(160 + k) && m_last == (k == 2), "R6", m_data, 160 + k);
          k++;
        end
      end
      @(negedge clk); m_ready = 0; done = 1; src_dir();
      @(negedge clk); done = 0; src_dir();
      repeat (5) begin @(negedge clk); src_dir(); end
      check(dn == DEPTH + 3, "R8", dn, DEPTH + 3);
      // long packet (20 > DEPTH) must pass without done
      k = 0;
      for (int c = 0; c < 300 && k < 20; c++) begin
        @(negedge clk); src_dir(); m_ready = ($urandom % 2) != 0;
        if (m_valid && m_ready) begin
          check(m_data == 8'(176 + k) && m_last == (k == 19), "R9", m_data, 176 + k);
          k++;
        end
      end
      check(k == 20, "R9", k, 20);
    end
    @(negedge clk); m_ready = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule